// File: doc/BRIEF.md
# Exception Stack Frame Writer

This block pushes an eight-word exception frame onto the supervisor stack when the core takes an access fault or finds the floating-point unit disabled. A single request carries the fault class, the status register, the current stack pointer, the vector number, two program counter candidates (the faulting instruction and the one after it), a fault address, a computed effective address and a 32-bit fault status word. On that cycle the block chooses what goes into each frame field and captures the whole frame. It then writes the frame out one 16-bit word at a time through a memory write port with a valid/ready handshake.

The stacked program counter and the two trailing longwords depend on the fault class. A read fault stacks the faulting instruction so that it restarts. A write fault to precise space stacks the same instruction. A write fault to imprecise space stacks the instruction after it. A disabled floating-point operation stacks the next instruction, the operand effective address and the address of the opcode word. When the last word is accepted, the block pulses done and presents the lowered stack pointer.

Top module: `excf_frame_writer`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `mem_valid` and `done` are low and `sp_out` is zero until a frame completes.
- R2: An accepted request produces exactly eight word writes. The first is at `sp_in - 16` and each following one is 2 bytes higher.
- R3: The word at offset 0 is `sr_in`. The word at offset 6 carries the format code 4'b0100 in bits 15:12 and `vector_in * 4` in bits 11:0.
- R4: For class 0 (read access error), the 32-bit field at offset 2 is `fault_pc_in`, the field at offset 8 is `fault_addr_in` and the field at offset 12 is `fslw_in`.
- R5: For class 1 (write error, precise space), offset 2 holds `fault_pc_in`, offset 8 holds `fault_addr_in` as the logical operand address, and offset 12 holds `fslw_in`.
- R6: For class 2 (write error, imprecise space), offset 2 holds `next_pc_in`, offset 8 holds `fault_addr_in` and offset 12 holds `fslw_in`.
- R7: For class 3 (floating-point disabled), offset 2 holds `next_pc_in`, offset 8 holds `ea_in` and offset 12 holds `fault_pc_in`.
- R8: Each 32-bit field is written with its upper 16 bits at the lower address.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.
- R10: `busy` is high from the cycle after acceptance until the last word is accepted. Requests during that time are ignored, and changes to the request inputs after acceptance do not alter the frame.
- R11: In the cycle after the eighth word is accepted, `done` is high for exactly one cycle, `busy` is low and `sp_out` equals `sp_in - 16` of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fault request; taken when not busy |
| req_class | input | 2 | Fault class: 0 read, 1 precise write, 2 imprecise write, 3 FP disabled |
| sr_in | input | 16 | Status register to stack |
| sp_in | input | 32 | Stack pointer before the push |
| vector_in | input | 8 | Exception vector number |
| fault_pc_in | input | 32 | Address of the faulting instruction |
| next_pc_in | input | 32 | Address of the following instruction |
| fault_addr_in | input | 32 | Faulting access address |
| ea_in | input | 32 | Computed operand effective address |
| fslw_in | input | 32 | Fault status longword |
| mem_valid | output | 1 | Word write request |
| mem_addr | output | 32 | Byte address of the word |
| mem_data | output | 16 | Word to write |
| mem_ready | input | 1 | Memory accepts the word |
| busy | output | 1 | Frame write in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 32 | Stack pointer after the push |

## Verification
Each of the four fault classes is driven with its two PC candidates, its two address sources and its status word all set to different values. A swapped or wrong field choice therefore shows up as a specific wrong word. One run lets the memory accept every cycle and another accepts only every third cycle, which shows whether the port holds its word during stalls and still steps its addresses correctly. A run that changes every input and raises a second request in the middle of a frame tells a latched frame apart from a live one. A stack pointer near zero and the largest vector number check the address wrap and the full width of the vector offset.

// File: rtl/excf_pkg.sv
package excf_pkg;
  localparam int unsigned LW_W        = 32;
  localparam int unsigned HW_W        = 16;
  localparam int unsigned FRAME_WORDS = 8;
  localparam int unsigned FRAME_BYTES = FRAME_WORDS * 2;
  localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);
  localparam int unsigned VOFF_W      = 12;
  localparam logic [3:0]  FRAME_FMT   = 4'b0100;

  typedef enum logic [1:0] {
    FC_READ_ERR     = 2'd0,
    FC_WR_PRECISE   = 2'd1,
    FC_WR_IMPRECISE = 2'd2,
    FC_FPU_OFF      = 2'd3
  } fault_class_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PUSH = 1'b1
  } seq_state_e;

  typedef logic [FRAME_WORDS-1:0][HW_W-1:0] frame_t;
endpackage

// File: rtl/excf_field_sel.sv
module excf_field_sel
  import excf_pkg::*;
(
  input  logic [1:0]      fclass,
  input  logic [LW_W-1:0] fault_pc,
  input  logic [LW_W-1:0] next_pc,
  input  logic [LW_W-1:0] fault_addr,
  input  logic [LW_W-1:0] eff_addr,
  input  logic [LW_W-1:0] fslw,
  output logic [LW_W-1:0] pc_sel,
  output logic [LW_W-1:0] addr_sel,
  output logic [LW_W-1:0] tail_sel
);
  fault_class_e cls;
  assign cls = fault_class_e'(fclass);

  always_comb begin
    pc_sel   = fault_pc;
    addr_sel = fault_addr;
    tail_sel = fslw;
    unique case (cls)
      FC_READ_ERR:     pc_sel = fault_pc;
      FC_WR_PRECISE:   pc_sel = fault_pc;
      FC_WR_IMPRECISE: pc_sel = next_pc;
      FC_FPU_OFF: begin
        pc_sel   = next_pc;
        addr_sel = eff_addr;
        tail_sel = fault_pc;
      end
      default: pc_sel = fault_pc;
    endcase
  end
endmodule

// File: rtl/excf_frame_pack.sv
module excf_frame_pack
  import excf_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic [HW_W-1:0]  sr,
  input  logic [VEC_W-1:0] vector,
  input  logic [LW_W-1:0]  pc_f,
  input  logic [LW_W-1:0]  addr_f,
  input  logic [LW_W-1:0]  tail_f,
  output frame_t           frame
);
  localparam int unsigned N_LW = 3;

  logic [VOFF_W-1:0]         voff;
  logic [N_LW-1:0][LW_W-1:0] lw;

  function automatic int unsigned lw_base(input int unsigned k);
    case (k)
      0:       lw_base = 1;
      1:       lw_base = 4;
      default: lw_base = 6;
    endcase
  endfunction

  assign voff = VOFF_W'(vector) << 2;
  assign lw   = {tail_f, addr_f, pc_f};

  always_comb begin
    frame    = '0;
    frame[0] = sr;
    frame[3] = {FRAME_FMT, voff};
    for (int unsigned k = 0; k < N_LW; k++) begin
      frame[lw_base(k)]     = lw[k][LW_W-1:HW_W];
      frame[lw_base(k) + 1] = lw[k][HW_W-1:0];
    end
  end
endmodule

// File: rtl/excf_seq.sv
module excf_seq
  import excf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start,
  input  logic             mem_ready,
  output logic             push_active,
  output logic [IDX_W-1:0] idx,
  output logic             finish,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             accept;

  assign accept = (st_q == ST_PUSH) && mem_ready;
  assign finish = accept && (idx_q == LAST_IDX);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_PUSH;
        idx_d = '0;
      end
      ST_PUSH: if (accept) begin
        if (idx_q == LAST_IDX) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign push_active = (st_q == ST_PUSH);
  assign idx         = idx_q;
  assign done        = done_q;
endmodule

// File: rtl/excf_frame_writer.sv
module excf_frame_writer
  import excf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_class,
  input  logic [15:0]       sr_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [VEC_W-1:0]  vector_in,
  input  logic [31:0]       fault_pc_in,
  input  logic [31:0]       next_pc_in,
  input  logic [31:0]       fault_addr_in,
  input  logic [31:0]       ea_in,
  input  logic [31:0]       fslw_in,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_data,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp_out
);
  localparam logic [ADDR_W-1:0] FRAME_SIZE = ADDR_W'(FRAME_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [LW_W-1:0]  pc_sel, addr_sel, tail_sel;
  frame_t           frame_d, frame_q;
  logic [ADDR_W-1:0] base_q, sp_out_q;
  logic             load, finish, push_active;
  logic [IDX_W-1:0] idx;

  excf_field_sel u_sel (
    .fclass     (req_class),
    .fault_pc   (fault_pc_in),
    .next_pc    (next_pc_in),
    .fault_addr (fault_addr_in),
    .eff_addr   (ea_in),
    .fslw       (fslw_in),
    .pc_sel     (pc_sel),
    .addr_sel   (addr_sel),
    .tail_sel   (tail_sel)
  );

  excf_frame_pack #(.VEC_W(VEC_W)) u_pack (
    .sr     (sr_in),
    .vector (vector_in),
    .pc_f   (pc_sel),
    .addr_f (addr_sel),
    .tail_f (tail_sel),
    .frame  (frame_d)
  );

  assign load = req_valid && !push_active;

  excf_seq u_seq (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .start       (load),
    .mem_ready   (mem_ready),
    .push_active (push_active),
    .idx         (idx),
    .finish      (finish),
    .done        (done)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      base_q  <= '0;
    end else if (load) begin
      frame_q <= frame_d;
      base_q  <= sp_in - FRAME_SIZE;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     sp_out_q <= '0;
    else if (finish) sp_out_q <= base_q;
  end

  assign mem_valid = push_active;
  assign mem_addr  = base_q + ADDR_W'({idx, 1'b0});
  assign mem_data  = frame_q[idx];
  assign busy      = push_active;
  assign sp_out    = sp_out_q;
endmodule

// File: rtl/excf_frame_writer_chk.sv
module excf_frame_writer_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_data,
  input logic              mem_ready,
  input logic              busy,
  input logic              done
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!busy && !mem_valid && !done));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + ADDR_W'(2))));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  p_valid_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_valid));

  p_done_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_valid && mem_ready));
endmodule

bind excf_frame_writer excf_frame_writer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .mem_ready (mem_ready),
  .busy      (busy),
  .done      (done)
);

// File: tb/excf_frame_writer_tb.sv
module excf_frame_writer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_class = '0;
  logic [15:0] sr_in = '0;
  logic [31:0] sp_in = '0;
  logic [7:0]  vector_in = '0;
  logic [31:0] fault_pc_in = '0, next_pc_in = '0, fault_addr_in = '0, ea_in = '0, fslw_in = '0;
  logic        mem_valid, mem_ready = 1'b0, busy, done;
  logic [31:0] mem_addr, sp_out;
  logic [15:0] mem_data;

  int vectors = 0;
  int errors  = 0;

  logic [31:0] cap_addr [8];
  logic [15:0] cap_data [8];
  int          ncap;
  int          done_seen;

  always #10 clk = ~clk;

  excf_frame_writer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .sr_in(sr_in), .sp_in(sp_in), .vector_in(vector_in),
    .fault_pc_in(fault_pc_in), .next_pc_in(next_pc_in),
    .fault_addr_in(fault_addr_in), .ea_in(ea_in), .fslw_in(fslw_in),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .busy(busy), .done(done), .sp_out(sp_out)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  // one frame: drive a request, serve the port, optionally disturb mid-frame
  task automatic run_frame(input logic [1:0] cls, input logic [31:0] sp, input logic [7:0] vec,
                           input int stall, input bit inject);
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [15:0] prev_data = '0;
    bit          injected = 1'b0;
    ncap = 0;
    done_seen = 0;
    @(negedge clk);
    req_class = cls; sr_in = 16'h2704 ^ {8'h0, vec}; sp_in = sp; vector_in = vec;
    fault_pc_in = 32'h0010_1000; next_pc_in = 32'h0010_1006;
    fault_addr_in = 32'hDEAD_0040; ea_in = 32'h0BAD_F00C; fslw_in = 32'h0123_4567;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      logic rdy;
      if (done) begin
        done_seen++;
        chk("R11", "word count at done", 32'(ncap), 32'd8);
        chk("R11", "busy at done", {31'b0, busy}, 32'd0);
        chk("R11", "sp_out", sp_out, sp - 32'd16);
        break;
      end
      if (prev_stall) begin
        chk("R9", "valid held", {31'b0, mem_valid}, 32'd1);
        chk("R9", "addr held", mem_addr, prev_addr);
        chk("R9", "data held", {16'b0, mem_data}, {16'b0, prev_data});
      end
      if (ncap < 8 && cyc < 100) chk("R10", "busy during frame", {31'b0, busy}, 32'd1);
      if (inject && ncap == 3 && !injected) begin
        injected = 1'b1;
        req_valid = 1'b1; req_class = ~cls; sr_in = 16'hFFFF; sp_in = 32'h5555_0000;
        vector_in = ~vec; fault_pc_in = 32'hAAAA_AAAA; next_pc_in = 32'hBBBB_BBBB;
        fault_addr_in = 32'hCCCC_CCCC; ea_in = 32'hDDDD_DDDD; fslw_in = 32'hEEEE_EEEE;
      end else begin
        req_valid = 1'b0;
      end
      rdy = (stall == 0) ? 1'b1 : ((cyc % stall) == stall - 1);
      mem_ready = rdy;
      prev_stall = mem_valid && !rdy;
      prev_addr = mem_addr;
      prev_data = mem_data;
      if (mem_valid && rdy && ncap < 8) begin
        cap_addr[ncap] = mem_addr;
        cap_data[ncap] = mem_data;
        ncap++;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    mem_ready = 1'b0;
    chk("R11", "done pulses", 32'(done_seen), 32'd1);
    @(negedge clk);
    chk("R11", "done one cycle", {31'b0, done}, 32'd0);
    chk("R10", "no second frame", {31'b0, mem_valid}, 32'd0);
  endtask

  task automatic check_frame(input string req, input logic [1:0] cls, input logic [31:0] sp, input logic [7:0] vec);
    logic [31:0] pc, ad, tl;
    logic [15:0] w [8];
    case (cls)
      2'd0, 2'd1: begin pc = 32'h0010_1000; ad = 32'hDEAD_0040; tl = 32'h0123_4567; end
      2'd2:       begin pc = 32'h0010_1006; ad = 32'hDEAD_0040; tl = 32'h0123_4567; end
      default:    begin pc = 32'h0010_1006; ad = 32'h0BAD_F00C; tl = 32'h0010_1000; end
    endcase
    w[0] = 16'h2704 ^ {8'h0, vec};
    w[1] = pc[31:16]; w[2] = pc[15:0];
    w[3] = {4'b0100, 12'({vec, 2'b00})};
    w[4] = ad[31:16]; w[5] = ad[15:0];
    w[6] = tl[31:16]; w[7] = tl[15:0];
    chk("R2", "write count", 32'(ncap), 32'd8);
    for (int i = 0; i < 8; i++) begin
      if (i < ncap) begin
        chk("R2", $sformatf("addr of word %0d", i), cap_addr[i], sp - 32'd16 + 32'(2 * i));
        chk((i == 0 || i == 3) ? "R3" : (i == 1 || i == 4 || i == 6) ? "R8" : req,
            $sformatf("data of word %0d", i), {16'b0, cap_data[i]}, {16'b0, w[i]});
      end
    end
  endtask

  task automatic t_reset_state();
    chk("R1", "busy", {31'b0, busy}, 32'd0);
    chk("R1", "mem_valid", {31'b0, mem_valid}, 32'd0);
    chk("R1", "done", {31'b0, done}, 32'd0);
    chk("R1", "sp_out", sp_out, 32'd0);
  endtask

  task automatic t_read_err();      run_frame(2'd0, 32'h0000_8000, 8'd2,   0, 1'b0); check_frame("R4", 2'd0, 32'h0000_8000, 8'd2);   endtask
  task automatic t_wr_precise();    run_frame(2'd1, 32'h0001_0010, 8'd3,   0, 1'b0); check_frame("R5", 2'd1, 32'h0001_0010, 8'd3);   endtask
  task automatic t_wr_imprecise();  run_frame(2'd2, 32'h7FFF_FFF0, 8'd2,   0, 1'b0); check_frame("R6", 2'd2, 32'h7FFF_FFF0, 8'd2);   endtask
  task automatic t_fpu_off();       run_frame(2'd3, 32'h0000_0008, 8'd255, 0, 1'b0); check_frame("R7", 2'd3, 32'h0000_0008, 8'd255); endtask
  task automatic t_stall();         run_frame(2'd2, 32'h0004_0000, 8'd11,  3, 1'b0); check_frame("R9", 2'd2, 32'h0004_0000, 8'd11);  endtask
  task automatic t_ignore();        run_frame(2'd3, 32'h0002_0100, 8'd13,  2, 1'b1); check_frame("R10", 2'd3, 32'h0002_0100, 8'd13); endtask

  initial begin
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_read_err();
    t_wr_precise();
    t_wr_imprecise();
    t_fpu_off();
    t_stall();
    t_ignore();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule